// File: doc/BRIEF.md
# Block-Level Column Repair Sequencer

This controller sits between a host and one memory block of 2^AW words. It masks stuck cells column by column. Every memory word holds the user data plus spare bits. Each host write is followed by a read-back. A mismatch at a bit that is not already covered claims a repair pointer, which names the failing column. From then on, that column's value is taken from the pointer's spare bit.

There are two kinds of pointer:

- **Word-scope pointers** are claimed first. Their spare carries a value bit and an in-use flag in each word, so only the failing word needs to be rewritten.
- **Block-scope pointers** are claimed once every word-scope pointer is used. Their spare is a single value bit with no flag. Claiming one therefore starts a sweep that reads, patches, writes and re-reads every word of the block, so that the new spare holds the right value everywhere.

A failure found during a sweep is not repaired at once. Its word, column and the value read before the failure are parked in a holding register, and a second sweep is run from it afterwards.

The host side is a command channel and a response channel, each with valid/ready. A command is taken only while `cmd_ready` is high, which is only when the controller is idle. A read response holds `rsp_data` steady until the host raises `rsp_ready`. `busy` and `exhausted` are plain status pins.

Top module: `colrep_block_seq`

## Requirements
- R1: Memory word layout. Bits [DW-1:0] hold data. Word-scope spare j has its value at bit DW+2j and its in-use flag at bit DW+2j+1. Block-scope spare b (pointer index NWR+b) is at bit DW+2*NWR+b. A host write fills every healthy claimed spare with the written data bit of its column, and writes zero into all other spare bits.
- R2: Each memory write is followed on the next cycle by a read of the same address. A write that reads back clean claims no pointer and ends three cycles after acceptance.
- R3: A new data-bit mismatch claims the lowest free word-scope pointer. The failing word is then rewritten and checked again, and later reads of it return the written data.
- R4: A word-scope spare is applied on a read only in words whose in-use flag is set. Words written before the pointer was claimed read their raw bits.
- R5: A mismatch in an in-use spare marks that pointer corrupted and claims another pointer for the same column. An error in a block-scope spare may claim only a block-scope pointer.
- R6: When no word-scope pointer is free, a new error claims the lowest free block-scope pointer. The controller then sweeps every word, taking four cycles per word, and keeps `busy` high and `cmd_ready` low for the whole sweep. It then rewrites the host word.
- R7: On a read, block-scope spares override word-scope spares, a higher index overrides a lower one, and pointers marked corrupted are skipped.
- R8: A data-bit failure found during a sweep is parked with its address, its column and the value read before the failure. Once the sweep ends, the parked entry claims a further block-scope pointer and starts a sweep that uses the parked value for that word.
- R9: An error that finds no free pointer sets `exhausted`, which stays set until reset, and the operation still completes.
- R10: After reset the outputs are `cmd_ready`=1, `busy`=0, `rsp_valid`=0, `exhausted`=0 and `mem_en`=0. A pending response keeps `rsp_valid` and `rsp_data` stable until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken (idle only) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | DW | Corrected read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW+2*NWR+NBR | Memory write word |
| mem_rdata | input | DW+2*NWR+NBR | Memory read word, valid the cycle after a read strobe |
| busy | output | 1 | Operation or sweep in progress |
| exhausted | output | 1 | An error found no free pointer (sticky) |

## Verification
The properties assume a memory that answers every read strobe with data on the next cycle, and a host that drops `cmd_valid` outside of idle and never withdraws an unacknowledged response. The bench memory model registers its read data one cycle after the strobe. The bench raises commands only after seeing `cmd_ready`, and holds `rsp_ready` low for one cycle before taking each response. Stuck cells are injected only between operations, by changing which bits the model forces on a write. A forced value opposite to the stored value is how a failure during a sweep is provoked.

// File: rtl/colrep_pkg.sv
package colrep_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WWR, S_WVR, S_WCMP,
    S_RRD, S_RCAP, S_RRSP,
    S_SRD, S_SMOD, S_SVR, S_SCMP, S_NEXT
  } colrep_st_t;
endpackage

// File: rtl/colrep_merge.sv
// Applies the spares selected by sel onto the raw data, lowest index first,
// so a higher index overrides a lower one on the same column.
module colrep_merge #(
  parameter int DW  = 8,
  parameter int NWR = 2,
  parameter int NBR = 3,
  parameter int PW  = 3
) (
  input  logic [DW+2*NWR+NBR-1:0]  raw,
  input  logic [(NWR+NBR)*PW-1:0]  pos,
  input  logic [NWR+NBR-1:0]       act,
  input  logic [NWR+NBR-1:0]       bad,
  input  logic [NWR+NBR-1:0]       sel,
  input  logic                     skip_bad,
  output logic [DW-1:0]            data
);
  localparam int T = NWR + NBR;

  logic [DW-1:0] stg [T+1];
  assign stg[0] = raw[DW-1:0];

  for (genvar i = 0; i < T; i++) begin : g_stage
    logic          en_w, val_w, hit_w;
    logic [PW-1:0] p_w;
    assign p_w = pos[i*PW +: PW];
    if (i < NWR) begin : g_word
      assign val_w = raw[DW+2*i];
      assign en_w  = raw[DW+2*i+1];
    end else begin : g_blk
      assign val_w = raw[DW+NWR+i];
      assign en_w  = 1'b1;
    end
    assign hit_w = sel[i] & act[i] & en_w & ~(skip_bad & bad[i]);
    assign stg[i+1] = hit_w ? ((stg[i] & ~(DW'(1) << p_w)) | (DW'(val_w) << p_w))
                            : stg[i];
  end

  assign data = stg[T];
endmodule

// File: rtl/colrep_scan.sv
// Compares the intended word with the read-back and reports the lowest new fault.
module colrep_scan #(
  parameter int DW  = 8,
  parameter int NWR = 2,
  parameter int NBR = 3,
  parameter int PW  = 3,
  parameter int IW  = 3
) (
  input  logic [DW+2*NWR+NBR-1:0]  want,
  input  logic [DW+2*NWR+NBR-1:0]  got,
  input  logic [(NWR+NBR)*PW-1:0]  pos,
  input  logic [NWR+NBR-1:0]       act,
  input  logic [NWR+NBR-1:0]       bad,
  input  logic                     chk_spare,
  output logic                     dat_err,
  output logic [PW-1:0]            dat_pos,
  output logic                     spr_err,
  output logic [IW-1:0]            spr_idx
);
  localparam int T  = NWR + NBR;
  localparam int MW = DW + 2*NWR + NBR;

  logic [MW-1:0] diff;
  logic [DW-1:0] covered, dat_bad;
  logic [T-1:0]  spr_bad;

  always_comb begin
    diff    = want ^ got;
    covered = '0;
    spr_bad = '0;
    for (int i = 0; i < T; i++) begin
      if (act[i]) covered[pos[i*PW +: PW]] = 1'b1;
      if (act[i] && !bad[i] && chk_spare) begin
        if (i < NWR) spr_bad[i] = |diff[DW+2*i +: 2];
        else         spr_bad[i] = diff[DW+NWR+i];
      end
    end
    dat_bad = diff[DW-1:0] & ~covered;
    dat_err = |dat_bad;
    dat_pos = '0;
    for (int i = DW-1; i >= 0; i--) if (dat_bad[i]) dat_pos = PW'(i);
    spr_err = |spr_bad;
    spr_idx = '0;
    for (int i = T-1; i >= 0; i--) if (spr_bad[i]) spr_idx = IW'(i);
  end
endmodule

// File: rtl/colrep_block_seq.sv
module colrep_block_seq #(
  parameter int DW  = 8,
  parameter int NWR = 2,
  parameter int NBR = 3,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_write,
  input  logic [AW-1:0]           cmd_addr,
  input  logic [DW-1:0]           cmd_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DW-1:0]           rsp_data,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [DW+2*NWR+NBR-1:0] mem_wdata,
  input  logic [DW+2*NWR+NBR-1:0] mem_rdata,
  output logic                    busy,
  output logic                    exhausted
);
  import colrep_pkg::*;

  localparam int T  = NWR + NBR;
  localparam int MW = DW + 2*NWR + NBR;
  localparam int PW = (DW > 1) ? $clog2(DW) : 1;
  localparam int IW = (T > 1) ? $clog2(T) : 1;

  colrep_st_t     st;
  logic [T*PW-1:0] pos_q;
  logic [T-1:0]   act_q, bad_q;
  logic [AW-1:0]  h_addr, cnt, ovr_addr, pend_addr;
  logic [DW-1:0]  h_wdata, rsp_q;
  logic [MW-1:0]  word_q;
  logic [IW-1:0]  cur_b;
  logic [PW-1:0]  pend_pos;
  logic           ovr_v, ovr_val, pend_v, pend_val, redo, exh_q;

  // free pointer search, lowest index first
  logic          wr_free, br_free;
  logic [IW-1:0] wr_idx, br_idx;
  always_comb begin
    wr_free = 1'b0; wr_idx = '0;
    br_free = 1'b0; br_idx = '0;
    for (int i = NWR-1; i >= 0; i--)
      if (!act_q[i]) begin wr_free = 1'b1; wr_idx = IW'(i); end
    for (int i = T-1; i >= NWR; i--)
      if (!act_q[i]) begin br_free = 1'b1; br_idx = IW'(i); end
  end

  // corrected data: all healthy spares on reads, only lower ones in a sweep
  logic          in_sweep;
  logic [T-1:0]  low_mask, mrg_sel;
  logic [DW-1:0] merged;
  assign in_sweep = (st == S_SMOD);
  assign low_mask = (T'(1) << cur_b) - T'(1);
  assign mrg_sel  = in_sweep ? low_mask : '1;

  colrep_merge #(.DW(DW), .NWR(NWR), .NBR(NBR), .PW(PW)) u_merge (
    .raw(mem_rdata), .pos(pos_q), .act(act_q), .bad(bad_q),
    .sel(mrg_sel), .skip_bad(!in_sweep), .data(merged)
  );

  logic          dat_err, spr_err;
  logic [PW-1:0] dat_pos;
  logic [IW-1:0] spr_idx;
  colrep_scan #(.DW(DW), .NWR(NWR), .NBR(NBR), .PW(PW), .IW(IW)) u_scan (
    .want(word_q), .got(mem_rdata), .pos(pos_q), .act(act_q), .bad(bad_q),
    .chk_spare(st == S_WCMP), .dat_err(dat_err), .dat_pos(dat_pos),
    .spr_err(spr_err), .spr_idx(spr_idx)
  );

  // host write word with every healthy claimed spare filled
  logic [MW-1:0] hw;
  always_comb begin
    hw = '0;
    hw[DW-1:0] = h_wdata;
    for (int i = 0; i < T; i++) begin
      if (act_q[i] && !bad_q[i]) begin
        if (i < NWR) begin
          hw[DW+2*i]   = h_wdata[pos_q[i*PW +: PW]];
          hw[DW+2*i+1] = 1'b1;
        end else begin
          hw[DW+NWR+i] = h_wdata[pos_q[i*PW +: PW]];
        end
      end
    end
  end

  // sweep word: raw read with the swept spare refreshed
  logic [PW-1:0] cur_pos;
  logic          corr;
  logic [MW-1:0] sw;
  assign cur_pos = pos_q[cur_b*PW +: PW];
  assign corr    = (ovr_v && ovr_addr == cnt) ? ovr_val : merged[cur_pos];
  always_comb begin
    sw = mem_rdata;
    sw[DW + NWR + int'(cur_b)] = corr;
  end

  // allocation request out of a host verify
  logic          a_req, a_wr_ok;
  logic [PW-1:0] a_pos;
  always_comb begin
    a_req   = dat_err | spr_err;
    a_pos   = dat_pos;
    a_wr_ok = 1'b1;
    if (!dat_err && spr_err) begin
      a_pos   = pos_q[spr_idx*PW +: PW];
      a_wr_ok = (int'(spr_idx) < NWR);
    end
  end

  // memory port
  always_comb begin
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = h_addr; mem_wdata = hw;
    unique case (st)
      S_WWR:  begin mem_en = 1'b1; mem_we = 1'b1; end
      S_WVR, S_RRD: mem_en = 1'b1;
      S_SRD, S_SVR: begin mem_en = 1'b1; mem_addr = cnt; end
      S_SMOD: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = cnt; mem_wdata = sw; end
      default: ;
    endcase
  end

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign rsp_valid = (st == S_RRSP);
  assign rsp_data  = rsp_q;
  assign exhausted = exh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pos_q <= '0; act_q <= '0; bad_q <= '0;
      h_addr <= '0; h_wdata <= '0; rsp_q <= '0; word_q <= '0;
      cnt <= '0; cur_b <= '0; ovr_v <= 1'b0; ovr_addr <= '0; ovr_val <= 1'b0;
      pend_v <= 1'b0; pend_addr <= '0; pend_pos <= '0; pend_val <= 1'b0;
      redo <= 1'b0; exh_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          h_addr  <= cmd_addr;
          h_wdata <= cmd_wdata;
          st      <= cmd_write ? S_WWR : S_RRD;
        end
        S_WWR: begin word_q <= hw; st <= S_WVR; end
        S_WVR: st <= S_WCMP;
        S_WCMP: begin
          if (!a_req) st <= S_IDLE;
          else begin
            if (!dat_err) bad_q[spr_idx] <= 1'b1;
            if (a_wr_ok && wr_free) begin
              act_q[wr_idx] <= 1'b1;
              pos_q[wr_idx*PW +: PW] <= a_pos;
              st <= S_WWR;
            end else if (br_free) begin
              act_q[br_idx] <= 1'b1;
              pos_q[br_idx*PW +: PW] <= a_pos;
              cur_b <= br_idx; cnt <= '0; ovr_v <= 1'b0; redo <= 1'b1;
              st <= S_SRD;
            end else begin
              exh_q <= 1'b1;
              st <= S_IDLE;
            end
          end
        end
        S_RRD:  st <= S_RCAP;
        S_RCAP: begin rsp_q <= merged; st <= S_RRSP; end
        S_RRSP: if (rsp_ready) st <= S_IDLE;
        S_SRD:  st <= S_SMOD;
        S_SMOD: begin word_q <= sw; st <= S_SVR; end
        S_SVR:  st <= S_SCMP;
        S_SCMP: begin
          if (dat_err && !pend_v) begin
            pend_v <= 1'b1; pend_addr <= cnt;
            pend_pos <= dat_pos; pend_val <= word_q[dat_pos];
          end
          if (cnt == '1) st <= S_NEXT;
          else begin cnt <= cnt + 1'b1; st <= S_SRD; end
        end
        S_NEXT: begin
          pend_v <= 1'b0;
          if (pend_v && br_free) begin
            act_q[br_idx] <= 1'b1;
            pos_q[br_idx*PW +: PW] <= pend_pos;
            cur_b <= br_idx; cnt <= '0;
            ovr_v <= 1'b1; ovr_addr <= pend_addr; ovr_val <= pend_val;
            st <= S_SRD;
          end else begin
            if (pend_v) exh_q <= 1'b1;
            ovr_v <= 1'b0;
            redo  <= 1'b0;
            st    <= redo ? S_WWR : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/colrep_chk.sv
module colrep_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          exhausted,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  // R6
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R9
  exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |=> exhausted);
  // R2
  verify_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |=> mem_en && !mem_we && mem_addr == $past(mem_addr));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
endmodule

bind colrep_block_seq colrep_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .exhausted(exhausted), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/colrep_block_seq_tb.sv
`timescale 1ns/1ps
module colrep_block_seq_tb_top;
  localparam int DW = 8, NWR = 2, NBR = 3, AW = 3;
  localparam int MW = DW + 2*NWR + NBR;
  localparam int NWORD = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, busy, exhausted, mem_en, mem_we;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic [MW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  colrep_block_seq #(.DW(DW), .NWR(NWR), .NBR(NBR), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .exhausted(exhausted)
  );

  // memory model with forced (stuck) cells applied on writes
  logic [MW-1:0] mem [NWORD];
  logic [MW-1:0] sm  [NWORD];
  logic [MW-1:0] sv  [NWORD];
  initial for (int i = 0; i < NWORD; i++) begin mem[i] = '0; sm[i] = '0; sv[i] = '0; end
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= (mem_wdata & ~sm[mem_addr]) | (sv[mem_addr] & sm[mem_addr]);
    else        mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  logic [DW-1:0] expd [NWORD];

  // {addr, data}
  localparam logic [AW+DW-1:0] VEC [NWORD] = '{
    {3'd0, 8'h3C}, {3'd1, 8'hA5}, {3'd2, 8'h0F}, {3'd3, 8'hF0},
    {3'd4, 8'h5A}, {3'd5, 8'hC3}, {3'd6, 8'h99}, {3'd7, 8'h66}};

  task automatic chk(input string req, input int actv, input int expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
    chk("R10 response held", int'(rsp_valid && rsp_data == d), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic read_all(input string req);
    logic [DW-1:0] r;
    for (int i = 0; i < NWORD; i++) begin
      do_read(AW'(i), r);
      chk(req, int'(r), int'(expd[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int cyc;
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cmd_ready", int'(cmd_ready), 1);
    chk("R10 busy", int'(busy), 0);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 exhausted", int'(exhausted), 0);
    chk("R10 mem_en", int'(mem_en), 0);
    rst_n = 1'b1;

    // R1 R2: fault-free table walk
    for (int i = 0; i < NWORD; i++) begin
      do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], cyc);
      expd[VEC[i][AW+DW-1:DW]] = VEC[i][DW-1:0];
      chk("R2 clean write cycles", cyc, 3);
      do_read(VEC[i][AW+DW-1:DW], r);
      chk("R1 clean read", int'(r), int'(VEC[i][DW-1:0]));
    end

    // R3: column 2 of word 1 stuck at 0
    sm[1][2] = 1'b1; sv[1][2] = 1'b0;
    do_write(3'd1, 8'hFF, cyc); expd[1] = 8'hFF;
    chk("R3 word-scope repair cycles", cyc, 6);
    do_read(3'd1, r);
    chk("R3 repaired read", int'(r), 8'hFF);
    // R4: word 0 spare flag clear, stale spare value 0 must not apply
    do_read(3'd0, r);
    chk("R4 inactive spare ignored", int'(r), 8'h3C);

    // R5: value bit of word-scope spare 0 stuck at 0 in word 1
    sm[1][DW] = 1'b1; sv[1][DW] = 1'b0;
    do_write(3'd1, 8'h5E, cyc); expd[1] = 8'h5E;
    chk("R5 spare fault repair cycles", cyc, 6);
    do_read(3'd1, r);
    chk("R5 replacement spare used", int'(r), 8'h5E);

    // R6 R8: word-scope full; a sweep fault in word 6 column 4 is deferred
    sm[6][4] = 1'b1; sv[6][4] = 1'b0;
    sm[4][0] = 1'b1; sv[4][0] = 1'b0;
    do_write(3'd4, 8'hB1, cyc); expd[4] = 8'hB1;
    chk("R8 two sweeps run", int'(cyc >= 4*NWORD*2 && cyc < 4*NWORD*3), 1);
    chk("R9 not exhausted yet", int'(exhausted), 0);
    read_all("R6 R8 block contents after sweeps");

    // R5 R7: block-scope spare 1 (bit DW+2*NWR+1) stuck at 0 in word 7
    sm[7][DW+2*NWR+1] = 1'b1; sv[7][DW+2*NWR+1] = 1'b0;
    do_write(3'd7, 8'h1F, cyc); expd[7] = 8'h1F;
    chk("R6 single sweep", int'(cyc >= 4*NWORD && cyc < 4*NWORD*2), 1);
    do_read(3'd7, r);
    chk("R7 word 7 via newest block spare", int'(r), 8'h1F);
    do_read(3'd6, r);
    chk("R7 word 6 keeps column 4", int'(r), 8'h99);
    chk("R9 still not exhausted", int'(exhausted), 0);

    // R9: all pointers used
    sm[3][7] = 1'b1; sv[3][7] = 1'b1;
    do_write(3'd3, 8'h70, cyc);
    chk("R9 exhausted set", int'(exhausted), 1);
    chk("R9 operation completes", int'(busy), 0);
    do_write(3'd0, 8'h3C, cyc);
    chk("R9 exhausted sticky", int'(exhausted), 1);
    do_read(3'd5, r);
    chk("R7 untouched word", int'(r), 8'hC3);

    summary();
  end
endmodule